// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block is the master side of a serial audio link in the I2S family. It takes mono sample words from an internal transmit FIFO and drives three lines: a bit clock, a word-select line and serial data. A frame is two system words long. The sample sits in the first word, sent most significant bit first and left-aligned. The second word is always zero. The bit clock comes from the system clock through a fixed even divider, so one serial bit lasts `CLK_DIV` system clocks.

The static settings come from plain input ports: word-select polarity, bit-clock polarity, system word length and data word length. The block copies them into internal registers only while it is idle, and it holds them for as long as it runs. Mute is live. It pulls the data line low in the same cycle, and frame timing and FIFO draining go on as normal.

The block keeps two sticky event flags, one for transmit underflow and one for transmit overflow. It also reports when it is idle. Each of these three conditions has its own interrupt enable.

Top module: `sat_tx`

## Requirements
- R1: After reset the block is idle, `sd` is 0, both sticky flags are 0, `cfg_error` is 0 and no interrupt output is asserted.
- R2: The system length codes 0, 1, 2 and 3 select 8, 16, 24 and 32 bits per system word. A frame is two system words. Each bit lasts `CLK_DIV` system clocks, and `ws` changes only at bit boundaries.
- R3: The data length codes 0 to 5 select 8, 16, 18, 20, 22 and 24 bits. The sample is `wr_data[L-1:0]`, sent MSB first from the first bit of the first system word. Bits past L are 0. If L is larger than the system word, only the top bits that fit are sent.
- R4: A latched system length code above 3 or data length code above 5 drives `cfg_error` high, and the block stays idle while `tx_en` is high.
- R5: With `cfg_ws_pol`=0, `ws` is low in the first system word and high in the second. With `cfg_ws_pol`=1 both levels are inverted. While idle, `ws` rests at the first-word level.
- R6: With `cfg_clk_pol`=0, `sck` is low in the first half of each bit and high in the second, so data changes on the falling edge. With 1 both levels are inverted. While idle, `sck` rests at the level opposite the first half.
- R7: While `cfg_mute` is 1, `sd` is 0 in the same cycle. Frame timing goes on, every frame start still consumes a FIFO word, and an empty FIFO still raises underflow.
- R8: `sd` is 0 for the whole second system word.
- R9: The configuration ports are copied only while idle, and not in the cycle that transmission starts. Changes to them while running have no effect on `ws`, `sck` or `sd`.
- R10: If the FIFO is empty at a frame start, that frame carries all zeros and `underflow_flag` is set. The flag stays set until a `clr_underflow` pulse. A new event in the same cycle as the clear wins.
- R11: The FIFO holds 8 words. A write while it is full is dropped and sets `overflow_flag`, which `clr_overflow` clears. A set in the same cycle as the clear wins.
- R12: `irq_underflow`, `irq_overflow` and `irq_idle` are each the AND of their condition (underflow flag, overflow flag, idle) and their enable input.
- R13: With a valid latched configuration, the block leaves idle on the first clock edge where `tx_en` is 1 and starts a frame. When a frame ends with `tx_en` at 0, it returns to idle. Otherwise the next frame follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Run request; sampled at every frame end |
| cfg_ws_pol | input | 1 | Word-select polarity |
| cfg_clk_pol | input | 1 | Bit-clock polarity |
| cfg_sys_len | input | 3 | System word length code |
| cfg_data_len | input | 3 | Data word length code |
| cfg_mute | input | 1 | Force data low immediately |
| wr_valid | input | 1 | Write strobe into the FIFO |
| wr_data | input | 24 | Sample word, right-justified |
| clr_underflow | input | 1 | Clear pulse for the underflow flag |
| clr_overflow | input | 1 | Clear pulse for the overflow flag |
| ie_underflow | input | 1 | Underflow interrupt enable |
| ie_overflow | input | 1 | Overflow interrupt enable |
| ie_idle | input | 1 | Idle interrupt enable |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select |
| sd | output | 1 | Serial data |
| idle | output | 1 | Transmitter is idle |
| cfg_error | output | 1 | Latched configuration uses a prohibited code |
| underflow_flag | output | 1 | Sticky transmit underflow |
| overflow_flag | output | 1 | Sticky transmit overflow |
| irq_underflow | output | 1 | Gated underflow interrupt |
| irq_overflow | output | 1 | Gated overflow interrupt |
| irq_idle | output | 1 | Gated idle interrupt |

## Verification
The assertions assume that reset is held for at least one clock before it is released, and that `CLK_DIV` is even and at least 2. The word-select stability check also assumes that the latched configuration never moves while running. The stimulus drives every input one time unit after a rising edge, so it is stable at each edge. It changes the configuration ports only while idle, except for a deliberate change in mid-run that tests the ignore rule. Mute and the clear pulses are driven at arbitrary points, because the assertions take nothing for granted about their timing.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int SAMPLE_W = 24;
    localparam int IDX_W    = 6;

    typedef enum logic {ST_IDLE, ST_RUN} sat_state_t;

    typedef struct packed {
        logic       ws_pol;
        logic       clk_pol;
        logic [2:0] sys_code;
        logic [2:0] dat_code;
    } sat_cfg_t;

    function automatic logic [5:0] sys_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 6'd8;
            3'd1:    return 6'd16;
            3'd2:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [4:0] dat_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd8;
            3'd1:    return 5'd16;
            3'd2:    return 5'd18;
            3'd3:    return 5'd20;
            3'd4:    return 5'd22;
            default: return 5'd24;
        endcase
    endfunction

    function automatic logic cfg_bad(input sat_cfg_t c);
        return (c.sys_code > 3'd3) || (c.dat_code > 3'd5);
    endfunction

endpackage

// File: rtl/sat_fifo.sv
module sat_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         drop
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step_ptr(wp);
            if (do_pop)  rp <= step_ptr(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        push && full && !pop |=> full); // R11

endmodule

// File: rtl/sat_frame_ctrl.sv
module sat_frame_ctrl
    import sat_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  sat_cfg_t         cfg_in,
    output sat_cfg_t         cfg_q,
    output logic             running,
    output logic [IDX_W-1:0] bit_idx,
    output logic             frame_load,
    output logic             cfg_err,
    output logic             sck,
    output logic             ws
);
    localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int HALF  = CLK_DIV / 2;

    sat_state_t       state;
    logic [DIV_W-1:0] div_cnt;
    logic [5:0]       sysb;
    logic [6:0]       last_idx;
    logic             start, bit_end, last_bit;

    assign sysb       = sys_bits(cfg_q.sys_code);
    assign last_idx   = {sysb, 1'b0} - 7'd1;
    assign running    = (state == ST_RUN);
    assign cfg_err    = cfg_bad(cfg_q);
    assign start      = !running && tx_en && !cfg_err;
    assign bit_end    = running && (div_cnt == DIV_W'(CLK_DIV - 1));
    assign last_bit   = ({1'b0, bit_idx} == last_idx);
    assign frame_load = start || (bit_end && last_bit && tx_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg_q   <= '0;
            div_cnt <= '0;
            bit_idx <= '0;
        end else if (!running) begin
            if (start) begin
                state   <= ST_RUN;
                div_cnt <= '0;
                bit_idx <= '0;
            end else begin
                cfg_q <= cfg_in;
            end
        end else if (bit_end) begin
            div_cnt <= '0;
            if (last_bit) begin
                bit_idx <= '0;
                if (!tx_en) state <= ST_IDLE;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign sck = (running ? (div_cnt >= DIV_W'(HALF)) : 1'b1) ^ cfg_q.clk_pol;
    assign ws  = (running ? (bit_idx >= sysb) : 1'b0) ^ cfg_q.ws_pol;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        running && $past(running) |-> $stable(cfg_q)); // R9
    AST_BAD_CFG_IDLE: assert property (@(posedge clk) disable iff (rst)
        !running && cfg_err |=> !running); // R4
    AST_WS_ON_BIT: assert property (@(posedge clk) disable iff (rst)
        running && $past(running) && !$past(bit_end) |-> $stable(ws)); // R2

endmodule

// File: rtl/sat_serializer.sv
module sat_serializer
    import sat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                running,
    input  logic                mute,
    input  logic                frame_load,
    input  logic [IDX_W-1:0]    bit_idx,
    input  sat_cfg_t            cfg_q,
    input  logic [SAMPLE_W-1:0] fifo_dout,
    input  logic                fifo_empty,
    output logic                pop,
    output logic                uf_evt,
    output logic                sd
);
    logic [SAMPLE_W-1:0] frame_word;
    logic [5:0]          sysb;
    logic [4:0]          datb;
    logic [4:0]          pos;

    assign sysb   = sys_bits(cfg_q.sys_code);
    assign datb   = dat_bits(cfg_q.dat_code);
    assign pop    = frame_load && !fifo_empty;
    assign uf_evt = frame_load && fifo_empty;

    always_ff @(posedge clk) begin
        if (rst)             frame_word <= '0;
        else if (frame_load) frame_word <= fifo_empty ? '0 : fifo_dout;
    end

    always_comb begin
        pos = datb - 5'd1 - bit_idx[4:0];
        sd  = 1'b0;
        if (running && !mute && (bit_idx < sysb) && (bit_idx < {1'b0, datb}))
            sd = frame_word[pos];
    end

    AST_UF_ZERO_WORD: assert property (@(posedge clk) disable iff (rst)
        uf_evt |=> frame_word == '0); // R10

endmodule

// File: rtl/sat_tx.sv
module sat_tx
    import sat_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tx_en,
    input  logic                cfg_ws_pol,
    input  logic                cfg_clk_pol,
    input  logic [2:0]          cfg_sys_len,
    input  logic [2:0]          cfg_data_len,
    input  logic                cfg_mute,
    input  logic                wr_valid,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic                clr_underflow,
    input  logic                clr_overflow,
    input  logic                ie_underflow,
    input  logic                ie_overflow,
    input  logic                ie_idle,
    output logic                sck,
    output logic                ws,
    output logic                sd,
    output logic                idle,
    output logic                cfg_error,
    output logic                underflow_flag,
    output logic                overflow_flag,
    output logic                irq_underflow,
    output logic                irq_overflow,
    output logic                irq_idle
);
    sat_cfg_t            cfg_in, cfg_q;
    logic                running, frame_load, pop, uf_evt, of_evt;
    logic                fifo_empty, fifo_full;
    logic [IDX_W-1:0]    bit_idx;
    logic [SAMPLE_W-1:0] fifo_dout;

    assign cfg_in = '{ws_pol: cfg_ws_pol, clk_pol: cfg_clk_pol,
                      sys_code: cfg_sys_len, dat_code: cfg_data_len};

    sat_fifo #(.DEPTH(FIFO_DEPTH), .W(SAMPLE_W)) u_fifo (
        .clk(clk), .rst(rst), .push(wr_valid), .pop(pop), .din(wr_data),
        .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full), .drop(of_evt)
    );

    sat_frame_ctrl #(.CLK_DIV(CLK_DIV)) u_ctrl (
        .clk(clk), .rst(rst), .tx_en(tx_en), .cfg_in(cfg_in), .cfg_q(cfg_q),
        .running(running), .bit_idx(bit_idx), .frame_load(frame_load),
        .cfg_err(cfg_error), .sck(sck), .ws(ws)
    );

    sat_serializer u_ser (
        .clk(clk), .rst(rst), .running(running), .mute(cfg_mute),
        .frame_load(frame_load), .bit_idx(bit_idx), .cfg_q(cfg_q),
        .fifo_dout(fifo_dout), .fifo_empty(fifo_empty),
        .pop(pop), .uf_evt(uf_evt), .sd(sd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            underflow_flag <= 1'b0;
            overflow_flag  <= 1'b0;
        end else begin
            underflow_flag <= uf_evt || (underflow_flag && !clr_underflow);
            overflow_flag  <= of_evt || (overflow_flag && !clr_overflow);
        end
    end

    assign idle          = !running;
    assign irq_underflow = underflow_flag && ie_underflow;
    assign irq_overflow  = overflow_flag && ie_overflow;
    assign irq_idle      = idle && ie_idle;

    AST_UF_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(underflow_flag) && !$past(clr_underflow) |-> underflow_flag); // R10
    AST_OF_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(overflow_flag) && !$past(clr_overflow) |-> overflow_flag); // R11

endmodule

// File: tb/sat_tx_test.sv
module sat_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int DEPTH      = 8;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 0, cfg_ws_pol = 0, cfg_clk_pol = 0, cfg_mute = 0;
    logic [2:0] cfg_sys_len = 0, cfg_data_len = 0;
    logic wr_valid = 0;
    logic [23:0] wr_data = 0;
    logic clr_underflow = 0, clr_overflow = 0;
    logic ie_underflow = 0, ie_overflow = 0, ie_idle = 0;
    logic sck, ws, sd, idle, cfg_error, underflow_flag, overflow_flag;
    logic irq_underflow, irq_overflow, irq_idle;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sat_tx #(.CLK_DIV(DIV), .FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .cfg_ws_pol(cfg_ws_pol),
        .cfg_clk_pol(cfg_clk_pol), .cfg_sys_len(cfg_sys_len),
        .cfg_data_len(cfg_data_len), .cfg_mute(cfg_mute), .wr_valid(wr_valid),
        .wr_data(wr_data), .clr_underflow(clr_underflow), .clr_overflow(clr_overflow),
        .ie_underflow(ie_underflow), .ie_overflow(ie_overflow), .ie_idle(ie_idle),
        .sck(sck), .ws(ws), .sd(sd), .idle(idle), .cfg_error(cfg_error),
        .underflow_flag(underflow_flag), .overflow_flag(overflow_flag),
        .irq_underflow(irq_underflow), .irq_overflow(irq_overflow), .irq_idle(irq_idle)
    );

    // Behavioural reference model
    int m_q[$];
    bit m_run = 0, m_wsp = 0, m_ckp = 0, m_uf = 0, m_of = 0;
    int m_sys = 0, m_dl = 0, m_div = 0, m_bit = 0, m_word = 0;

    function automatic int sys_len_bits(int c);
        return 8 * (c + 1);
    endfunction
    function automatic int dat_len_bits(int c);
        return (c == 0) ? 8 : 14 + 2 * c;
    endfunction
    function automatic bit m_err();
        return (m_sys > 3) || (m_dl > 5);
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int pre;
        bit load, uf_e, of_e;
        int sb;
        cycles++;
        if (cycles > WATCHDOG) begin
            n_fail++;
            $display("FAIL R13 watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
        if (rst) begin
            m_run = 0; m_wsp = 0; m_ckp = 0; m_uf = 0; m_of = 0;
            m_sys = 0; m_dl = 0; m_div = 0; m_bit = 0; m_word = 0;
            m_q.delete();
        end else begin
            pre = m_q.size();
            load = 0;
            sb = sys_len_bits(m_sys);
            if (!m_run) begin
                if (tx_en && !m_err()) begin
                    m_run = 1; m_div = 0; m_bit = 0; load = 1;
                end else begin
                    m_wsp = cfg_ws_pol; m_ckp = cfg_clk_pol;
                    m_sys = cfg_sys_len; m_dl = cfg_data_len;
                end
            end else if (m_div == DIV - 1) begin
                m_div = 0;
                if (m_bit == 2 * sb - 1) begin
                    m_bit = 0;
                    if (tx_en) load = 1; else m_run = 0;
                end else m_bit++;
            end else m_div++;
            uf_e = 0;
            if (load) begin
                if (pre > 0) m_word = m_q.pop_front();
                else begin m_word = 0; uf_e = 1; end
            end
            of_e = wr_valid && (pre >= DEPTH);
            if (wr_valid && pre < DEPTH) m_q.push_back(int'(wr_data));
            m_uf = uf_e || (m_uf && !clr_underflow);
            m_of = of_e || (m_of && !clr_overflow);
        end
    end

    always @(negedge clk) begin
        int sb, dl;
        logic e_sd, e_ws, e_sck;
        string sd_tag;
        if (!rst) begin
            sb = sys_len_bits(m_sys);
            dl = dat_len_bits(m_dl);
            e_sd = 1'b0;
            sd_tag = "R3";
            if (cfg_mute) sd_tag = "R7";
            else if (m_run && m_bit >= sb) sd_tag = "R8";
            if (m_run && !cfg_mute && m_bit < sb && m_bit < dl)
                e_sd = logic'((m_word >> (dl - 1 - m_bit)) & 1);
            e_ws  = (m_run ? (m_bit >= sb) : 1'b0) ^ m_wsp;
            e_sck = (m_run ? (m_div >= DIV / 2) : 1'b1) ^ m_ckp;
            chk(sd_tag, "sd", sd, e_sd);
            chk("R2 R5 R9", "ws", ws, e_ws);
            chk("R6 R9", "sck", sck, e_sck);
            chk("R13", "idle", idle, !m_run);
            chk("R4", "cfg_error", cfg_error, m_err());
            chk("R10", "underflow_flag", underflow_flag, m_uf);
            chk("R11", "overflow_flag", overflow_flag, m_of);
            chk("R12", "irq_underflow", irq_underflow, m_uf && ie_underflow);
            chk("R12", "irq_overflow", irq_overflow, m_of && ie_overflow);
            chk("R12", "irq_idle", irq_idle, !m_run && ie_idle);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [23:0] d);
        wr_valid = 1; wr_data = d;
        step(1);
        wr_valid = 0;
    endtask

    task automatic set_cfg(input logic wsp, input logic ckp, input logic [2:0] s, input logic [2:0] d);
        cfg_ws_pol = wsp; cfg_clk_pol = ckp; cfg_sys_len = s; cfg_data_len = d;
        step(2);
    endtask

    task automatic pulse_clr();
        clr_underflow = 1; clr_overflow = 1;
        step(1);
        clr_underflow = 0; clr_overflow = 0;
    endtask

    initial begin
        step(4);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "idle after reset", idle, 1'b1);
        chk("R1", "sd after reset", sd, 1'b0);
        chk("R1", "underflow after reset", underflow_flag, 1'b0);
        chk("R1", "overflow after reset", overflow_flag, 1'b0);
        chk("R1", "cfg_error after reset", cfg_error, 1'b0);
        step(1);

        // 8-bit words, 8-bit data, normal polarities, then underflow (R10)
        set_cfg(0, 0, 3'd0, 3'd0);
        push(24'h0000A5); push(24'h00003C); push(24'h0000FF);
        tx_en = 1;
        step(16 * DIV * 4 + 5);
        tx_en = 0;
        step(16 * DIV + 4);
        ie_underflow = 1; ie_idle = 1;
        step(3);
        pulse_clr();

        // 32-bit words, 24-bit data, inverted polarities, mid-run changes (R9), mute (R7)
        set_cfg(1, 1, 3'd3, 3'd5);
        push(24'hC35A96); push(24'h800001); push(24'h7FFFFE);
        tx_en = 1;
        step(50);
        cfg_ws_pol = 0; cfg_clk_pol = 0; cfg_sys_len = 3'd0; cfg_data_len = 3'd6;
        step(100);
        cfg_mute = 1;
        step(37);
        cfg_mute = 0;
        step(64 * DIV * 3);
        tx_en = 0;
        step(64 * DIV + 4);
        pulse_clr();

        // 16-bit words with 18-bit data: truncation (R3)
        set_cfg(0, 1, 3'd1, 3'd2);
        push(24'h02D2B7); push(24'h015555);
        tx_en = 1;
        step(32 * DIV * 3);
        tx_en = 0;
        step(32 * DIV + 4);
        pulse_clr();

        // 24-bit words, 22-bit data, muted throughout: FIFO still drains (R7)
        set_cfg(1, 0, 3'd2, 3'd4);
        cfg_mute = 1;
        push(24'h2ABCDE); push(24'h155555);
        tx_en = 1;
        step(48 * DIV * 3);
        tx_en = 0;
        step(48 * DIV + 4);
        cfg_mute = 0;
        pulse_clr();

        // 20 and 16 bit data in 32-bit words, then empty FIFO
        set_cfg(0, 0, 3'd3, 3'd3);
        push(24'h0ABCDE);
        tx_en = 1;
        step(64 * DIV + 2);
        tx_en = 0;
        step(64 * DIV * 2);
        set_cfg(0, 0, 3'd3, 3'd1);
        push(24'h00F00F);
        tx_en = 1;
        step(64 * DIV);
        tx_en = 0;
        step(64 * DIV + 4);
        pulse_clr();

        // Overflow: fill past depth while idle (R11), irq gating (R12)
        ie_overflow = 0;
        for (int i = 0; i < DEPTH + 2; i++) push(24'(i * 3 + 1));
        step(2);
        ie_overflow = 1;
        step(2);
        clr_overflow = 1; wr_valid = 1; wr_data = 24'h111111;
        step(1);
        clr_overflow = 0; wr_valid = 0;
        step(2);
        pulse_clr();
        ie_idle = 0;
        step(2);

        // Prohibited codes keep the block idle (R4)
        set_cfg(0, 0, 3'd0, 3'd7);
        tx_en = 1;
        step(20);
        tx_en = 0;
        set_cfg(0, 0, 3'd5, 3'd0);
        tx_en = 1;
        step(20);
        tx_en = 0;
        set_cfg(0, 0, 3'd0, 3'd0);
        tx_en = 1;
        step(16 * DIV * 2);
        tx_en = 0;
        step(16 * DIV + 4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule